// File: doc/BRIEF.md
# Two-Side Duty-Cycle Calibration Sequencer

This block calibrates a single duty-cycle correction lane in two passes through one shared search engine. It launches a pass on side A from the seed it is given. It then derives a new seed from the side A result and launches a pass on side B. Once both passes have returned, it merges the two results into one final correction code.

When both passes succeed, the final code is the average of the two results. When only one pass fails, the code the other pass found is used. When both passes fail, the seed that was held is kept. A failed pass never aborts the run. Instead, each side's failure is reported on its own status output, so a recovered failure can still be seen.

On completion the block raises a single-cycle done strobe and presents the write-back word in the same cycle. The final code and the per-side status stay stable until the next run completes.

Top module: `dcc_two_side_seq`

## Requirements
- R1: A start pulse taken while idle launches the side A pass first. The launch is a one-cycle engine start with side select 1 (side A) and the engine seed equal to the input seed.
- R2: After side A returns, a one-cycle engine start is issued with side select 0 (side B). Its seed is the side A result minus one when side A passed with a nonzero result. Otherwise it is the original input seed.
- R3: When both passes pass, the final code is floor((A + B) / 2), computed without loss of the carry bit.
- R4: When only side B fails, the final code equals the side A result.
- R5: When only side A fails, the final code equals the side B result.
- R6: When both passes fail, the final code equals the seed that was held, which is the original input seed. The done strobe is still raised.
- R7: `done_o` is high for exactly one cycle per run. In that cycle `wb_valid_o` is high and `wb_word_o` is {compare-out bit = 0 at the most significant position, final code below it}. `final_code_o` holds its value until the next done.
- R8: A start pulse that arrives while a run is in progress is ignored. It changes neither the held seed nor the sequence, and it causes no further engine launch after done.
- R9: `fail_a_o` and `fail_b_o` report the fail status each side's engine pass returned. They are updated when done is raised and then held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a two-side calibration run (taken only while idle) |
| seed_i | input | CODE_W | Starting correction code for side A |
| eng_start_o | output | 1 | One-cycle launch strobe to the search engine |
| eng_side_o | output | 1 | Side select for the launch: 1 = side A, 0 = side B |
| eng_seed_o | output | CODE_W | Seed handed to the search engine |
| eng_done_i | input | 1 | Search engine finished the current pass |
| eng_fail_i | input | 1 | Search engine pass failed (valid with eng_done_i) |
| eng_result_i | input | CODE_W | Code found by the pass (valid with eng_done_i) |
| done_o | output | 1 | One-cycle completion strobe |
| final_code_o | output | CODE_W | Merged final correction code |
| fail_a_o | output | 1 | Side A pass failed in the last run |
| fail_b_o | output | 1 | Side B pass failed in the last run |
| wb_valid_o | output | 1 | Write-back word valid |
| wb_word_o | output | CODE_W+1 | Write-back word: compare-out bit (forced 0) above the final code |

## Verification
A wrong reseed value shows up on `eng_seed_o` in the very cycle the side B launch strobe is raised. That is one cycle after the engine reports side A done, well before any final code exists. An error in the merge or in the stored side A result shows up on `final_code_o` and `wb_word_o` in the done cycle, one cycle after side B's done. A control state that accepted a stray start would show as an extra engine launch within a couple of cycles after done, or as a changed both-fail fallback code.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_LAUNCH_A = 3'd1,
    ST_WAIT_A   = 3'd2,
    ST_LAUNCH_B = 3'd3,
    ST_WAIT_B   = 3'd4,
    ST_DONE     = 3'd5
  } seq_state_e;

  localparam logic SIDE_A = 1'b1;
  localparam logic SIDE_B = 1'b0;

endpackage

// File: rtl/dcc_seq_fsm.sv
module dcc_seq_fsm
  import dcc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic eng_done_i,
  output logic cap_seed_o,
  output logic cap_a_o,
  output logic cap_b_o,
  output logic eng_start_o,
  output logic eng_side_o,
  output logic done_o
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (start_i) state_d = ST_LAUNCH_A;
      ST_LAUNCH_A: state_d = ST_WAIT_A;
      ST_WAIT_A:   if (eng_done_i) state_d = ST_LAUNCH_B;
      ST_LAUNCH_B: state_d = ST_WAIT_B;
      ST_WAIT_B:   if (eng_done_i) state_d = ST_DONE;
      ST_DONE:     state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign cap_seed_o  = (state_q == ST_IDLE) && start_i;
  assign cap_a_o     = (state_q == ST_WAIT_A) && eng_done_i;
  assign cap_b_o     = (state_q == ST_WAIT_B) && eng_done_i;
  assign eng_start_o = (state_q == ST_LAUNCH_A) || (state_q == ST_LAUNCH_B);
  assign eng_side_o  = (state_q == ST_LAUNCH_A) ? SIDE_A : SIDE_B;
  assign done_o      = (state_q == ST_DONE);

  // R8
  busy_start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) && start_i |=> (state_q != ST_LAUNCH_A));

  // R1
  launch_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |=> !eng_start_o);

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

endmodule

// File: rtl/dcc_side_store.sv
module dcc_side_store #(
  parameter int CODE_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_seed_i,
  input  logic              cap_a_i,
  input  logic              cap_b_i,
  input  logic [CODE_W-1:0] seed_i,
  input  logic [CODE_W-1:0] eng_result_i,
  input  logic              eng_fail_i,
  output logic [CODE_W-1:0] seed_o,
  output logic [CODE_W-1:0] seed_b_o,
  output logic [CODE_W-1:0] res_a_o,
  output logic              fail_a_o,
  output logic [CODE_W-1:0] res_b_o,
  output logic              fail_b_o
);

  logic [CODE_W-1:0] seed_q, seed_b_q, res_a_q, res_b_q;
  logic              fail_a_q, fail_b_q;
  logic              keep_seed;

  // a failed or zero side A result leaves the seed untouched
  assign keep_seed = eng_fail_i || (eng_result_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seed_q   <= '0;
      seed_b_q <= '0;
      res_a_q  <= '0;
      res_b_q  <= '0;
      fail_a_q <= 1'b0;
      fail_b_q <= 1'b0;
    end else begin
      if (cap_seed_i) begin
        seed_q   <= seed_i;
        seed_b_q <= seed_i;
      end
      if (cap_a_i) begin
        res_a_q  <= eng_result_i;
        fail_a_q <= eng_fail_i;
        seed_b_q <= keep_seed ? seed_q : eng_result_i - 1'b1;
      end
      if (cap_b_i) begin
        res_b_q  <= eng_result_i;
        fail_b_q <= eng_fail_i;
      end
    end
  end

  assign seed_o   = seed_q;
  assign seed_b_o = seed_b_q;
  assign res_a_o  = res_a_q;
  assign fail_a_o = fail_a_q;
  assign res_b_o  = res_b_q;
  assign fail_b_o = fail_b_q;

  // R2
  reseed_below_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_a_i && !eng_fail_i && (eng_result_i != '0) |=> (seed_b_q < res_a_q));

endmodule

// File: rtl/dcc_merge.sv
module dcc_merge #(
  parameter int CODE_W = 7
) (
  input  logic [CODE_W-1:0] held_seed_i,
  input  logic [CODE_W-1:0] res_a_i,
  input  logic              fail_a_i,
  input  logic [CODE_W-1:0] res_b_i,
  input  logic              fail_b_i,
  output logic [CODE_W-1:0] code_o
);

  localparam int SUM_W = CODE_W + 1;

  logic [SUM_W-1:0] sum;

  assign sum = {1'b0, res_a_i} + {1'b0, res_b_i};

  always_comb begin
    unique case ({fail_a_i, fail_b_i})
      2'b00:   code_o = sum[SUM_W-1:1];
      2'b01:   code_o = res_a_i;
      2'b10:   code_o = res_b_i;
      default: code_o = held_seed_i;
    endcase
  end

endmodule

// File: rtl/dcc_two_side_seq.sv
module dcc_two_side_seq #(
  parameter int CODE_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CODE_W-1:0] seed_i,
  output logic              eng_start_o,
  output logic              eng_side_o,
  output logic [CODE_W-1:0] eng_seed_o,
  input  logic              eng_done_i,
  input  logic              eng_fail_i,
  input  logic [CODE_W-1:0] eng_result_i,
  output logic              done_o,
  output logic [CODE_W-1:0] final_code_o,
  output logic              fail_a_o,
  output logic              fail_b_o,
  output logic              wb_valid_o,
  output logic [CODE_W:0]   wb_word_o
);

  localparam logic CMP_OUT_WB = 1'b0;

  logic              cap_seed, cap_a, cap_b;
  logic [CODE_W-1:0] seed_q, seed_b_q, res_a_q, res_b_q, merged;
  logic              fail_a_q, fail_b_q;
  logic [CODE_W-1:0] final_q;
  logic              stat_a_q, stat_b_q;

  dcc_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .eng_done_i  (eng_done_i),
    .cap_seed_o  (cap_seed),
    .cap_a_o     (cap_a),
    .cap_b_o     (cap_b),
    .eng_start_o (eng_start_o),
    .eng_side_o  (eng_side_o),
    .done_o      (done_o)
  );

  dcc_side_store #(.CODE_W(CODE_W)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cap_seed_i   (cap_seed),
    .cap_a_i      (cap_a),
    .cap_b_i      (cap_b),
    .seed_i       (seed_i),
    .eng_result_i (eng_result_i),
    .eng_fail_i   (eng_fail_i),
    .seed_o       (seed_q),
    .seed_b_o     (seed_b_q),
    .res_a_o      (res_a_q),
    .fail_a_o     (fail_a_q),
    .res_b_o      (res_b_q),
    .fail_b_o     (fail_b_q)
  );

  // side B outcome is merged straight from the engine at its done edge
  dcc_merge #(.CODE_W(CODE_W)) u_merge (
    .held_seed_i (seed_b_q),
    .res_a_i     (res_a_q),
    .fail_a_i    (fail_a_q),
    .res_b_i     (eng_result_i),
    .fail_b_i    (eng_fail_i),
    .code_o      (merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      final_q  <= '0;
      stat_a_q <= 1'b0;
      stat_b_q <= 1'b0;
    end else if (cap_b) begin
      final_q  <= merged;
      stat_a_q <= fail_a_q;
      stat_b_q <= eng_fail_i;
    end
  end

  assign eng_seed_o   = eng_side_o ? seed_q : seed_b_q;
  assign final_code_o = final_q;
  assign fail_a_o     = stat_a_q;
  assign fail_b_o     = stat_b_q;
  assign wb_valid_o   = done_o;
  assign wb_word_o    = {CMP_OUT_WB, final_q};

  // R6
  both_fail_seed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fail_a_o && fail_b_o |-> (final_code_o == seed_q));

  // R3
  average_bounds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !fail_a_o && !fail_b_o |->
      ((final_code_o >= res_a_q) || (final_code_o >= res_b_q)) &&
      ((final_code_o <= res_a_q) || (final_code_o <= res_b_q)));

  // R9
  status_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (fail_b_o == fail_b_q) && (fail_a_o == fail_a_q));

  // R7
  final_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o && !cap_b |=> $stable(final_code_o));

endmodule

// File: tb/dcc_two_side_seq_bench.sv
module dcc_two_side_seq_bench;

  localparam int CODE_W = 7;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [CODE_W-1:0] seed_i = '0;
  logic              eng_start_o, eng_side_o;
  logic [CODE_W-1:0] eng_seed_o;
  logic              eng_done_i = 1'b0;
  logic              eng_fail_i = 1'b0;
  logic [CODE_W-1:0] eng_result_i = '0;
  logic              done_o, fail_a_o, fail_b_o, wb_valid_o;
  logic [CODE_W-1:0] final_code_o;
  logic [CODE_W:0]   wb_word_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dcc_two_side_seq #(.CODE_W(CODE_W)) u_dcc_two_side_seq (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .start_i      (start_i),
    .seed_i       (seed_i),
    .eng_start_o  (eng_start_o),
    .eng_side_o   (eng_side_o),
    .eng_seed_o   (eng_seed_o),
    .eng_done_i   (eng_done_i),
    .eng_fail_i   (eng_fail_i),
    .eng_result_i (eng_result_i),
    .done_o       (done_o),
    .final_code_o (final_code_o),
    .fail_a_o     (fail_a_o),
    .fail_b_o     (fail_b_o),
    .wb_valid_o   (wb_valid_o),
    .wb_word_o    (wb_word_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_start();
    for (int n = 0; n < 50 && !eng_start_o; n++) @(negedge clk);
  endtask

  task automatic wait_done();
    for (int n = 0; n < 50 && !done_o; n++) @(negedge clk);
  endtask

  task automatic respond(input logic [CODE_W-1:0] res, input bit fail, input int lat);
    repeat (lat) @(negedge clk);
    eng_done_i   = 1'b1;
    eng_result_i = res;
    eng_fail_i   = fail;
    @(negedge clk);
    eng_done_i   = 1'b0;
    eng_result_i = '0;
    eng_fail_i   = 1'b0;
  endtask

  task automatic run_case(input string name, input int seed,
                          input int ra, input bit fa, input int rb, input bit fb,
                          input int exp_seed_b, input int exp_final, input bit poke);
    @(negedge clk);
    start_i = 1'b1;
    seed_i  = seed[CODE_W-1:0];
    @(negedge clk);
    start_i = 1'b0;
    seed_i  = '0;
    wait_start();
    // R1
    chk(eng_start_o && eng_side_o == 1'b1, {name, " R1 side A launch"}, eng_side_o, 1);
    chk(eng_seed_o == seed[CODE_W-1:0], {name, " R1 seed A"}, eng_seed_o, seed);
    if (poke) begin
      @(negedge clk);
      start_i = 1'b1;
      seed_i  = 7'd99;
      @(negedge clk);
      start_i = 1'b0;
      seed_i  = '0;
    end
    respond(ra[CODE_W-1:0], fa, 2);
    wait_start();
    // R2
    chk(eng_start_o && eng_side_o == 1'b0, {name, " R2 side B launch"}, eng_side_o, 0);
    chk(eng_seed_o == exp_seed_b[CODE_W-1:0], {name, " R2 seed B"}, eng_seed_o, exp_seed_b);
    respond(rb[CODE_W-1:0], fb, 3);
    wait_done();
    // R3 R4 R5 R6 final code
    chk(done_o && final_code_o == exp_final[CODE_W-1:0], {name, " R3-6 final"},
        final_code_o, exp_final);
    // R7 write-back word
    chk(wb_valid_o && wb_word_o == {1'b0, exp_final[CODE_W-1:0]}, {name, " R7 wb word"},
        wb_word_o, exp_final);
    // R9
    chk(fail_a_o == fa && fail_b_o == fb, {name, " R9 status"},
        {fail_a_o, fail_b_o}, {fa, fb});
    @(negedge clk);
    chk(!done_o && !wb_valid_o, {name, " R7 done single pulse"}, done_o, 0);
  endtask

  task automatic test_reset();
    chk(!done_o && !eng_start_o && !wb_valid_o, "R7 reset strobes low", done_o, 0);
    chk(final_code_o == '0 && !fail_a_o && !fail_b_o, "R9 reset outputs", final_code_o, 0);
  endtask

  task automatic test_no_relaunch();
    bit seen = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (eng_start_o) seen = 1'b1;
    end
    // R8
    chk(!seen, "R8 no launch from busy start", seen, 0);
    // R7 hold
    chk(final_code_o == 7'd20, "R7 final held", final_code_o, 20);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    run_case("both_pass",   40, 50,  0, 47,  0, 49, 48, 0);
    run_case("a_zero",      10, 0,   0, 5,   0, 10, 2,  0);
    run_case("b_fails",     64, 70,  0, 127, 1, 69, 70, 0);
    run_case("a_fails",     30, 127, 1, 33,  0, 30, 33, 0);
    run_case("max_codes",  127, 127, 0, 127, 0, 126, 127, 0);
    run_case("odd_sum",      5, 1,   0, 2,   0, 0,  1,  0);
    run_case("both_fail",   20, 0,   1, 127, 1, 20, 20, 1);
    test_no_relaunch();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule